// File: doc/BRIEF.md
# Snoop-Aware Load-Reserve Reservation Tracker

This block holds the one load-reserve reservation of a write-through data cache that owns a shared memory bus, and it runs the bus cycle for a store-conditional. A reserving load gives its cache index and way in pipeline cycle 0. It gives its translated real address in cycle 1. It reports that its data has arrived with a one-cycle pulse. Stores that other bus agents perform arrive as snoops. Each snoop carries a real address and, when it hits in the cache, an index and a way. A snoop to the reserved line removes the reservation. The block compares the reserved line with the snoop of the current cycle and also with the snoop of the previous cycle. It compares index and way for a snoop that lands in the same cycle as the reserving load's first cycle.

A store-conditional is checked at the end of its second cycle. If it may proceed, it drives bus cycle and strobe. If the reservation is lost while the strobe is still waiting for the bus to accept it, both are withdrawn in that same cycle and the store-conditional fails. A quadword store-conditional keeps the bus cycle open after its first doubleword so that its second doubleword follows without any other master getting in between. The result comes back as a one-cycle done pulse with a pass flag.

Top module: `resv_tracker`

## Requirements
- R1: While reset is high and after it is released, resv_valid, bus_cyc, bus_stb and sc_done are all 0.
- R2: A request with op code 1 (reserving load) in cycle 0 captures the real address presented in cycle 1. resv_valid stays 0 until a data pulse arrives in cycle 2 or later, and it reads 1 from the cycle after that pulse.
- R3: A request with op code 2 (quadword reserving load) becomes valid on its first data pulse. A later data pulse for the second doubleword does not set resv_valid again after a snoop has cleared it.
- R4: A snoop whose address lies in the reserved line clears resv_valid by the next cycle. Line granularity is set by LINE_BITS: address bits below LINE_BITS are ignored, and a snoop to a different line leaves the reservation valid.
- R5: A snoop that hits the cache in cycle 0 of a reserving load, with the same index and way as that load, spoils the reservation, so the later data pulse leaves resv_valid at 0. A different way has no such effect.
- R6: A snoop in cycle 1 of a reserving load whose address falls in the line being reserved spoils the reservation through the previous-cycle comparison.
- R7: A store-conditional (op code 3) with no valid reservation, or with an address outside the reserved line, gives sc_done=1 with sc_pass=0 in cycle 2 and never raises bus_cyc.
- R8: A store-conditional that may proceed drives bus_cyc=bus_stb=1 from cycle 2 until a cycle with bus_stall=0. Next it holds bus_cyc=1 with bus_stb=0 until bus_ack. In the cycle after the ack it gives sc_done=1, sc_pass=1 and bus_cyc=0.
- R9: If the reservation is lost while the strobe is pending, bus_cyc and bus_stb fall in the same cycle as the snoop, and sc_done=1 with sc_pass=0 follows one cycle later.
- R10: resv_valid is 0 once a store-conditional has been refused, accepted by the bus or aborted.
- R11: For a quadword store-conditional (op code 4), after the first ack bus_cyc stays 1 with bus_stb=0 until a request with op code 5 (store) arrives. The next cycle drives bus_stb=1 whatever snoops have done, and the pass result comes one cycle after the second ack.
- R12: A store request (op code 5) outside a quadword store-conditional changes neither the reservation nor the bus, and it produces no sc_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present in its cycle 0 |
| req_op | input | 3 | Request op code (1 load-reserve, 2 quad load-reserve, 3 store-cond, 4 quad store-cond, 5 store) |
| req_index | input | IDX_W | Cache index of the request |
| req_way | input | WAY_W | Cache way of the request |
| c1_addr | input | ADDR_W | Real address of the request, given in its cycle 1 |
| ld_data_valid | input | 1 | Data (first doubleword) of the reserving load is available |
| snp_valid | input | 1 | Another agent performs a store |
| snp_addr | input | ADDR_W | Real address of the snooped store |
| snp_hit | input | 1 | Snooped store hits in the cache (index and way meaningful) |
| snp_index | input | IDX_W | Cache index of the snooped store |
| snp_way | input | WAY_W | Cache way of the snooped store |
| bus_stall | input | 1 | Bus not accepting the strobe this cycle |
| bus_ack | input | 1 | Bus acknowledges the write |
| resv_valid | output | 1 | Reservation is held |
| sc_done | output | 1 | Store-conditional finished (one-cycle pulse) |
| sc_pass | output | 1 | Store-conditional succeeded, qualified by sc_done |
| bus_cyc | output | 1 | Bus cycle held |
| bus_stb | output | 1 | Bus strobe for a store-conditional doubleword |

## Verification
The reservation changes at the clock edge that ends the cycle of its cause. For a reserving load, resv_valid is therefore sampled at the first falling edge after the data pulse. After a snoop it is sampled at the falling edge that follows that snoop's cycle. A store-conditional is refused in cycle 2, strobes from cycle 2 and reports pass one cycle after the final ack. Each expected pass or fail is queued when the request is driven and popped when sc_done appears, and that cycle is checked as well. The abort case samples bus_cyc and bus_stb a fraction of a cycle after the snoop is driven, within the same cycle, because the strobe must fall without waiting for an edge.

// File: rtl/resv_pkg.sv
package resv_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_LARX  = 3'd1,
        OP_LQARX = 3'd2,
        OP_STCX  = 3'd3,
        OP_STQCX = 3'd4,
        OP_STORE = 3'd5
    } rq_op_e;

    typedef enum logic [2:0] {
        SC_IDLE,
        SC_ISSUE,
        SC_WAITACK,
        SC_HOLD,
        SC_SECOND
    } sc_state_e;

    // What a request leaves behind for its cycle 1
    typedef struct packed {
        logic rsv;      // reserving load in flight
        logic sc;       // store-conditional in flight
        logic more;     // quadword: a second doubleword follows
        logic idx_hit;  // cycle-0 snoop matched index and way
    } c1_slot_t;

    function automatic logic op_reserves(rq_op_e op);
        return (op == OP_LARX) || (op == OP_LQARX);
    endfunction

    function automatic logic op_conditional(rq_op_e op);
        return (op == OP_STCX) || (op == OP_STQCX);
    endfunction

endpackage

// File: rtl/resv_line_cmp.sv
module resv_line_cmp #(
    parameter int LINE_W = 26
) (
    input  logic              en,
    input  logic [LINE_W-1:0] probe,
    input  logic [LINE_W-1:0] held,
    output logic              hit
);
    assign hit = en && (probe == held);
endmodule

// File: rtl/resv_hold.sv
module resv_hold #(
    parameter int LINE_W = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic              spoil_in,
    input  logic [LINE_W-1:0] line_in,
    input  logic              data_ok,
    input  logic              kill,
    input  logic              clr,
    output logic              valid,
    output logic [LINE_W-1:0] line
);
    logic pend;
    logic spoil;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            line  <= '0;
            pend  <= 1'b0;
            spoil <= 1'b0;
        end else if (commit) begin
            line  <= line_in;
            valid <= 1'b0;
            pend  <= 1'b1;
            spoil <= spoil_in;
        end else if (pend && data_ok) begin
            valid <= !(spoil || kill);
            pend  <= 1'b0;
            spoil <= 1'b0;
        end else begin
            if (kill || clr) valid <= 1'b0;
            if (pend && kill) spoil <= 1'b1;
        end
    end
endmodule

// File: rtl/resv_sc_fsm.sv
module resv_sc_fsm
    import resv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic more_in,
    input  logic resv_ok,
    input  logic live,
    input  logic stall,
    input  logic ack,
    input  logic second_req,
    output logic cyc,
    output logic stb,
    output logic done,
    output logic pass,
    output logic clr
);
    sc_state_e state;
    logic      more;

    always_comb begin
        cyc = 1'b0;
        stb = 1'b0;
        unique case (state)
            SC_ISSUE:   begin cyc = live; stb = live; end
            SC_WAITACK: cyc = 1'b1;
            SC_HOLD:    cyc = 1'b1;
            SC_SECOND:  begin cyc = 1'b1; stb = 1'b1; end
            default:    ;
        endcase
    end

    assign clr = ((state == SC_IDLE) && start && !resv_ok) ||
                 ((state == SC_ISSUE) && live && !stall);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SC_IDLE;
            more  <= 1'b0;
            done  <= 1'b0;
            pass  <= 1'b0;
        end else begin
            done <= 1'b0;
            pass <= 1'b0;
            unique case (state)
                SC_IDLE: if (start) begin
                    if (resv_ok) begin
                        state <= SC_ISSUE;
                        more  <= more_in;
                    end else begin
                        done <= 1'b1;
                    end
                end
                SC_ISSUE: begin
                    if (!live) begin
                        state <= SC_IDLE;
                        done  <= 1'b1;
                        more  <= 1'b0;
                    end else if (!stall) begin
                        state <= SC_WAITACK;
                    end
                end
                SC_WAITACK: if (ack) begin
                    if (more) begin
                        state <= SC_HOLD;
                        more  <= 1'b0;
                    end else begin
                        state <= SC_IDLE;
                        done  <= 1'b1;
                        pass  <= 1'b1;
                    end
                end
                SC_HOLD:   if (second_req) state <= SC_SECOND;
                SC_SECOND: if (!stall) state <= SC_WAITACK;
                default:   state <= SC_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/resv_tracker.sv
module resv_tracker
    import resv_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LINE_BITS = 6,
    parameter int IDX_W     = 6,
    parameter int WAY_W     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [IDX_W-1:0]  req_index,
    input  logic [WAY_W-1:0]  req_way,
    input  logic [ADDR_W-1:0] c1_addr,
    input  logic              ld_data_valid,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              snp_hit,
    input  logic [IDX_W-1:0]  snp_index,
    input  logic [WAY_W-1:0]  snp_way,
    input  logic              bus_stall,
    input  logic              bus_ack,
    output logic              resv_valid,
    output logic              sc_done,
    output logic              sc_pass,
    output logic              bus_cyc,
    output logic              bus_stb
);
    localparam int LINE_W = ADDR_W - LINE_BITS;
    localparam int NCMP   = 3;   // 0: snoop now, 1: snoop last cycle, 2: request address

    rq_op_e op;
    assign op = rq_op_e'(req_op);

    // cycle-0 capture of the request
    c1_slot_t slot_d, slot_q;
    always_comb begin
        slot_d.rsv     = req_valid && op_reserves(op);
        slot_d.sc      = req_valid && op_conditional(op);
        slot_d.more    = req_valid && (op == OP_STQCX);
        slot_d.idx_hit = snp_valid && snp_hit &&
                         (snp_index == req_index) && (snp_way == req_way);
    end

    // snoop delayed by one cycle for the late comparison
    logic              snp_q_valid;
    logic [LINE_W-1:0] snp_q_line;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q      <= '0;
            snp_q_valid <= 1'b0;
            snp_q_line  <= '0;
        end else begin
            slot_q      <= slot_d;
            snp_q_valid <= snp_valid;
            snp_q_line  <= snp_addr[ADDR_W-1:LINE_BITS];
        end
    end

    logic [LINE_W-1:0] resv_line;
    logic [NCMP-1:0]   cmp_en;
    logic [LINE_W-1:0] cmp_probe [NCMP];
    logic [NCMP-1:0]   cmp_hit;

    assign cmp_en       = {1'b1, snp_q_valid, snp_valid};
    assign cmp_probe[0] = snp_addr[ADDR_W-1:LINE_BITS];
    assign cmp_probe[1] = snp_q_line;
    assign cmp_probe[2] = c1_addr[ADDR_W-1:LINE_BITS];

    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        resv_line_cmp #(.LINE_W(LINE_W)) u_cmp (
            .en    (cmp_en[g]),
            .probe (cmp_probe[g]),
            .held  (resv_line),
            .hit   (cmp_hit[g])
        );
    end

    logic kill;
    logic sc_clr;
    assign kill = cmp_hit[0] || cmp_hit[1];

    resv_hold #(.LINE_W(LINE_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .commit   (slot_q.rsv),
        .spoil_in (slot_q.idx_hit),
        .line_in  (c1_addr[ADDR_W-1:LINE_BITS]),
        .data_ok  (ld_data_valid),
        .kill     (kill),
        .clr      (sc_clr),
        .valid    (resv_valid),
        .line     (resv_line)
    );

    resv_sc_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (slot_q.sc),
        .more_in    (slot_q.more),
        .resv_ok    (resv_valid && cmp_hit[2] && !kill),
        .live       (resv_valid && !kill),
        .stall      (bus_stall),
        .ack        (bus_ack),
        .second_req (req_valid && (op == OP_STORE)),
        .cyc        (bus_cyc),
        .stb        (bus_stb),
        .done       (sc_done),
        .pass       (sc_pass),
        .clr        (sc_clr)
    );

    // offset within the line takes no part in matching
    logic lo_bits_unused;
    assign lo_bits_unused = ^{c1_addr[LINE_BITS-1:0], snp_addr[LINE_BITS-1:0]};
endmodule

// File: rtl/resv_tracker_chk.sv
module resv_tracker_chk #(
    parameter int LINE_W = 26
) (
    input logic              clk,
    input logic              rst,
    input logic              resv_valid,
    input logic [LINE_W-1:0] resv_line,
    input logic              snp_valid,
    input logic [LINE_W-1:0] snp_line,
    input logic              sc_done,
    input logic              sc_pass,
    input logic              bus_cyc,
    input logic              bus_stb
);
    AST_STB_INSIDE_CYC: assert property (@(posedge clk) disable iff (rst)
        bus_stb |-> bus_cyc);  // R8

    AST_PASS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        sc_pass |-> sc_done);  // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sc_done |=> !sc_done);  // R7

    AST_CLEAR_AFTER_SC: assert property (@(posedge clk) disable iff (rst)
        sc_done |-> !resv_valid);  // R10

    AST_SNOOP_KILLS: assert property (@(posedge clk) disable iff (rst)
        (resv_valid && snp_valid && (snp_line == resv_line)) |=> !resv_valid);  // R4
endmodule

bind resv_tracker resv_tracker_chk #(.LINE_W(ADDR_W - LINE_BITS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .resv_valid (resv_valid),
    .resv_line  (resv_line),
    .snp_valid  (snp_valid),
    .snp_line   (snp_addr[ADDR_W-1:LINE_BITS]),
    .sc_done    (sc_done),
    .sc_pass    (sc_pass),
    .bus_cyc    (bus_cyc),
    .bus_stb    (bus_stb)
);

// File: tb/sim_resv_tracker.sv
module sim_resv_tracker;
    localparam int AW = 32;
    localparam logic [31:0] A     = 32'h0000_1040;
    localparam logic [31:0] OTHER = 32'h0000_2000;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [2:0]  req_op;
    logic [5:0]  req_index;
    logic [1:0]  req_way;
    logic [31:0] c1_addr;
    logic        ld_data_valid;
    logic        snp_valid;
    logic [31:0] snp_addr;
    logic        snp_hit;
    logic [5:0]  snp_index;
    logic [1:0]  snp_way;
    logic        bus_stall;
    logic        bus_ack;
    logic        resv_valid, sc_done, sc_pass, bus_cyc, bus_stb;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    bit    exp_q[$];
    string tag_q[$];

    always #2.5ns clk = ~clk;

    resv_tracker u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_index(req_index), .req_way(req_way), .c1_addr(c1_addr),
        .ld_data_valid(ld_data_valid), .snp_valid(snp_valid), .snp_addr(snp_addr),
        .snp_hit(snp_hit), .snp_index(snp_index), .snp_way(snp_way),
        .bus_stall(bus_stall), .bus_ack(bus_ack), .resv_valid(resv_valid),
        .sc_done(sc_done), .sc_pass(sc_pass), .bus_cyc(bus_cyc), .bus_stb(bus_stb)
    );

    task automatic check_eq(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // scoreboard driver side
    task automatic expect_sc(bit pass, string tag);
        exp_q.push_back(pass);
        tag_q.push_back(tag);
    endtask

    // scoreboard monitor side
    always @(negedge clk) begin
        bit    e;
        string t;
        if (!rst && sc_done) begin
            if (exp_q.size() == 0) begin
                check_eq("R7", "unexpected sc_done", 1, 0);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check_eq(t, "sc_pass", {31'd0, sc_pass}, {31'd0, e});
            end
        end
    end

    // called just after a falling edge; returns just after the edge that starts cycle 2
    task automatic issue(input logic [2:0] op, input logic [31:0] addr,
                         input logic [5:0] idx, input logic [1:0] way,
                         input bit s0, input logic [1:0] s0_way,
                         input bit s1, input logic [31:0] s1_addr);
        req_valid = 1'b1; req_op = op; req_index = idx; req_way = way;
        if (s0) begin
            snp_valid = 1'b1; snp_hit = 1'b1; snp_index = idx; snp_way = s0_way;
            snp_addr = 32'h0000_9000;
        end
        @(negedge clk);
        req_valid = 1'b0; req_op = 3'd0; c1_addr = addr;
        snp_valid = 1'b0; snp_hit = 1'b0;
        if (s1) begin
            snp_valid = 1'b1; snp_addr = s1_addr;
        end
        @(negedge clk);
        c1_addr = '0; snp_valid = 1'b0;
    endtask

    task automatic pulse_data();
        ld_data_valid = 1'b1;
        @(negedge clk);
        ld_data_valid = 1'b0;
    endtask

    task automatic reserve(input logic [2:0] op, input logic [31:0] addr);
        issue(op, addr, 6'd3, 2'd0, 0, 2'd0, 0, '0);
        pulse_data();
    endtask

    task automatic snoop_once(input logic [31:0] addr);
        snp_valid = 1'b1; snp_addr = addr; snp_hit = 1'b0;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_valid = 0; req_op = 0; req_index = 0; req_way = 0;
        c1_addr = 0; ld_data_valid = 0; snp_valid = 0; snp_addr = 0; snp_hit = 0;
        snp_index = 0; snp_way = 0; bus_stall = 0; bus_ack = 0;
        repeat (3) @(negedge clk);
        check_eq("R1", "resv_valid in reset", resv_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1", "resv_valid", resv_valid, 0);
        check_eq("R1", "bus_cyc", bus_cyc, 0);
        check_eq("R1", "bus_stb", bus_stb, 0);
        check_eq("R1", "sc_done", sc_done, 0);

        // R2: valid only after the data pulse
        issue(3'd1, A, 6'd3, 2'd0, 0, 2'd0, 0, '0);
        check_eq("R2", "valid before data (cycle 2)", resv_valid, 0);
        @(negedge clk);
        check_eq("R2", "valid before data (cycle 3)", resv_valid, 0);
        pulse_data();
        check_eq("R2", "valid after data", resv_valid, 1);

        // R4: other line leaves it, same line other offset clears it
        snoop_once(OTHER);
        check_eq("R4", "other-line snoop", resv_valid, 1);
        @(negedge clk);
        check_eq("R4", "other-line snoop late", resv_valid, 1);
        snoop_once(A + 32'h8);
        check_eq("R4", "same-line snoop", resv_valid, 0);

        // R7: no reservation
        expect_sc(1'b0, "R7");
        issue(3'd3, A, 6'd3, 2'd0, 0, 2'd0, 0, '0);
        check_eq("R7", "done in cycle 2", sc_done, 1);
        check_eq("R7", "no bus_cyc", bus_cyc, 0);
        @(negedge clk);
        check_eq("R7", "no bus_cyc after", bus_cyc, 0);

        // R12: plain store is ignored
        reserve(3'd1, A);
        issue(3'd5, A, 6'd3, 2'd0, 0, 2'd0, 0, '0);
        check_eq("R12", "valid kept", resv_valid, 1);
        check_eq("R12", "no bus_cyc", bus_cyc, 0);
        @(negedge clk);
        check_eq("R12", "no sc_done", sc_done, 0);
        check_eq("R12", "valid kept later", resv_valid, 1);

        // R8 / R10: passing store-conditional
        bus_stall = 1'b0;
        expect_sc(1'b1, "R8");
        issue(3'd3, A + 32'h4, 6'd3, 2'd0, 0, 2'd0, 0, '0);
        check_eq("R8", "cyc cycle 2", bus_cyc, 1);
        check_eq("R8", "stb cycle 2", bus_stb, 1);
        @(negedge clk);
        check_eq("R8", "cyc waiting ack", bus_cyc, 1);
        check_eq("R8", "stb dropped", bus_stb, 0);
        check_eq("R10", "valid after accept", resv_valid, 0);
        @(negedge clk);
        check_eq("R8", "cyc still held", bus_cyc, 1);
        bus_ack = 1'b1;
        @(negedge clk);
        bus_ack = 1'b0;
        check_eq("R8", "done after ack", sc_done, 1);
        check_eq("R8", "cyc released", bus_cyc, 0);

        // R9: abort while strobing
        reserve(3'd1, A);
        bus_stall = 1'b1;
        expect_sc(1'b0, "R9");
        issue(3'd3, A, 6'd3, 2'd0, 0, 2'd0, 0, '0);
        check_eq("R9", "stb before loss", bus_stb, 1);
        @(negedge clk);
        snp_valid = 1'b1; snp_addr = A + 32'h4; snp_hit = 1'b0;
        #1ns;
        check_eq("R9", "cyc dropped same cycle", bus_cyc, 0);
        check_eq("R9", "stb dropped same cycle", bus_stb, 0);
        @(negedge clk);
        snp_valid = 1'b0; bus_stall = 1'b0;
        check_eq("R9", "fail reported", sc_done, 1);
        check_eq("R10", "valid after abort", resv_valid, 0);

        // R7 / R10: address outside the reserved line
        reserve(3'd1, A);
        expect_sc(1'b0, "R7");
        issue(3'd3, OTHER, 6'd3, 2'd0, 0, 2'd0, 0, '0);
        check_eq("R7", "mismatch done", sc_done, 1);
        check_eq("R7", "mismatch no cyc", bus_cyc, 0);
        check_eq("R10", "valid after refusal", resv_valid, 0);

        // R5: cycle-0 index/way snoop
        issue(3'd1, A, 6'd5, 2'd1, 1, 2'd1, 0, '0);
        pulse_data();
        check_eq("R5", "same index/way spoils", resv_valid, 0);
        issue(3'd1, A, 6'd5, 2'd1, 1, 2'd2, 0, '0);
        pulse_data();
        check_eq("R5", "other way harmless", resv_valid, 1);

        // R6: cycle-1 snoop via the late compare, data one cycle later
        issue(3'd1, A, 6'd3, 2'd0, 0, 2'd0, 1, A + 32'h10);
        @(negedge clk);
        pulse_data();
        check_eq("R6", "cycle-1 snoop spoils", resv_valid, 0);
        issue(3'd1, A, 6'd3, 2'd0, 0, 2'd0, 1, OTHER);
        pulse_data();
        check_eq("R6", "cycle-1 other line harmless", resv_valid, 1);

        // R3: quadword reserve
        issue(3'd2, A, 6'd3, 2'd0, 0, 2'd0, 0, '0);
        pulse_data();
        check_eq("R3", "valid on first beat", resv_valid, 1);
        snoop_once(A + 32'h20);
        pulse_data();
        check_eq("R3", "second beat does not revive", resv_valid, 0);

        // R11: quadword store-conditional
        issue(3'd2, A, 6'd3, 2'd0, 0, 2'd0, 0, '0);
        pulse_data();
        pulse_data();
        expect_sc(1'b1, "R11");
        issue(3'd4, A, 6'd3, 2'd0, 0, 2'd0, 0, '0);
        check_eq("R11", "first stb", bus_stb, 1);
        @(negedge clk);
        check_eq("R11", "wait ack stb", bus_stb, 0);
        bus_ack = 1'b1;
        @(negedge clk);
        bus_ack = 1'b0;
        check_eq("R11", "cyc held between dwords", bus_cyc, 1);
        check_eq("R11", "no stb while holding", bus_stb, 0);
        check_eq("R11", "no done yet", sc_done, 0);
        snp_valid = 1'b1; snp_addr = A;
        @(negedge clk);
        snp_valid = 1'b0;
        check_eq("R11", "cyc still held", bus_cyc, 1);
        req_valid = 1'b1; req_op = 3'd5;
        @(negedge clk);
        req_valid = 1'b0; req_op = 3'd0;
        check_eq("R11", "second stb", bus_stb, 1);
        @(negedge clk);
        check_eq("R11", "second wait ack", bus_stb, 0);
        bus_ack = 1'b1;
        @(negedge clk);
        bus_ack = 1'b0;
        check_eq("R11", "pass after second ack", sc_done, 1);
        check_eq("R11", "cyc released", bus_cyc, 0);

        repeat (3) @(negedge clk);
        check_eq("R7", "scoreboard drained", exp_q.size(), 0);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule